// File: doc/BRIEF.md
# Prescaled Countdown Watchdog Timer

A watchdog for a chip's housekeeping domain. It is built around a 16-bit down-counter that advances once per prescaler tick. Software sets up the block through a control word, then writes a reload value to the load word. Each later load write puts the counter back to the full interval, and that is how firmware services the watchdog. If the counter runs down to zero in watchdog mode, the block raises a fixed-length reset request for the chip's reset controller.

In the other modes the block behaves as a plain one-shot timer. It sets a sticky expiry flag and never requests a reset. A load value of zero parks the counter, so zero never causes an expiry. Loading 1 with no division gives an expiry one clock after the write, which firmware uses to force an immediate reset.

The bus is a single-cycle write strobe with a word offset. Read data is combinational from the offset.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0, `rst_req_o` is low and `expired_o` is low.
- R2: A write to offset 0x00 loads the counter with the written value, saturated to 0xFFFF when any bit above bit 15 is set. A read of offset 0x00 returns the current count, zero-extended.
- R3: The control word at offset 0x08 has these fields: prescale code in bits 3:0, mode in bits 5:4, enable in bit 7. Bit 6 is reserved and reads 0. A read returns these fields and also the expiry flag in bit 8.
- R4: Prescale code 0 ticks on every clock. Code n (n ≥ 1) ticks every 2^(n+1) clocks, so code 15 divides by 65536. With the block enabled, an expiry follows exactly L × divide clocks after the load write of value L.
- R5: With enable clear the count holds its value. Setting enable restarts the prescaler, so the first decrement comes one full divide period after that write.
- R6: A count of 0 never decrements and never expires, whatever the enable, mode and prescale settings.
- R7: A load write during a countdown restarts both the count and the prescaler. The next expiry comes a full interval after that write.
- R8: In mode 3, an expiry drives `rst_req_o` high for exactly 16 clocks, starting at the edge where the count reaches 0. An expiry that occurs while the pulse is active does not stretch it.
- R9: In modes 0, 1 and 2 an expiry never raises `rst_req_o`.
- R10: `expired_o` is set at every expiry in any mode. It stays set until the next load write clears it.
- R11: After an expiry the count stays at 0, with no further expiry, until software writes the load word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 4 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| rst_req_o | output | 1 | Reset request pulse (watchdog mode) |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
The bench times expiry to the exact clock for each prescale code, including codes 0, 1 and 15. An off-by-one in the divider limit, or a mapping that treats code 15 as 2^15, moves the expiry by whole divide periods.

Load value 0 must never expire. A design that decrements through zero would wrap to 0xFFFF and read back a nonzero count.

A service write in mid-count must restart the full interval. A design that kept the prescaler phase, or ignored the reload, would expire early.

The reset pulse is measured for its exact width, and must stay absent in the non-watchdog modes. After expiry the bench checks that the count stays parked and that no second pulse follows.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [3:0] LOAD_OFS = 4'h0;
  localparam logic [3:0] CTRL_OFS = 4'h8;
  localparam logic [1:0] MODE_WD  = 2'd3;
  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned MODE_LSB   = 4;
  localparam int unsigned STATUS_BIT = 8;

  typedef struct packed {
    logic       en;
    logic [1:0] mode;
    logic [3:0] psc;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              load_we_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              en_rise_o,
  output logic              status_o
);
  logic  ctrl_we;
  ctrl_t ctrl_q, ctrl_d;
  logic  status_q;

  assign load_we_o = bus_we_i && (bus_addr_i == ADDR_W'(LOAD_OFS));
  assign ctrl_we   = bus_we_i && (bus_addr_i == ADDR_W'(CTRL_OFS));

  // saturate reloads that do not fit the counter
  assign load_val_o = (|bus_wdata_i[DATA_W-1:CNT_W]) ? {CNT_W{1'b1}}
                                                     : bus_wdata_i[CNT_W-1:0];

  always_comb begin
    ctrl_d.en   = bus_wdata_i[EN_BIT];
    ctrl_d.mode = bus_wdata_i[MODE_LSB+:2];
    ctrl_d.psc  = bus_wdata_i[3:0];
  end

  assign en_rise_o = ctrl_we && ctrl_d.en && !ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= 1'b0;
    else if (load_we_o) status_q <= 1'b0;
    else if (expire_i)  status_q <= 1'b1;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(LOAD_OFS)) begin
      bus_rdata_o[CNT_W-1:0] = count_i;
    end else if (bus_addr_i == ADDR_W'(CTRL_OFS)) begin
      bus_rdata_o[STATUS_BIT]    = status_q;
      bus_rdata_o[EN_BIT]        = ctrl_q.en;
      bus_rdata_o[MODE_LSB+:2]   = ctrl_q.mode;
      bus_rdata_o[3:0]           = ctrl_q.psc;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PSC_W = 4,
  parameter int unsigned PC_W  = 1 << PSC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             tick_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] limit;

  // code 0 -> /1, code n -> /2^(n+1)
  always_comb begin
    if (code_i == '0) limit = '0;
    else              limit = {PC_W{1'b1}} >> (PC_W - 1 - int'(code_i));
  end

  assign tick_o = run_i && !restart_i && (pc_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pc_q <= '0;
    else if (restart_i || !run_i) pc_q <= '0;
    else if (tick_o)              pc_q <= '0;
    else                          pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign run_o    = en_i && (cnt_q != '0);
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_we_i)              cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int unsigned PULSE_CYCLES = 16,
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic wd_mode_i,
  output logic rst_req_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                left_q <= '0;
    else if (left_q != '0)                      left_q <= left_q - 1'b1;
    else if (expire_i && wd_mode_i)             left_q <= PW'(PULSE_CYCLES);
  end

  assign rst_req_o = (left_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned PSC_W        = 4,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o,
  output logic              expired_o
);
  localparam int unsigned PC_W = 1 << PSC_W;

  ctrl_t            ctrl_w;
  logic             load_we_w;
  logic [CNT_W-1:0] load_val_w;
  logic             en_rise_w;
  logic [CNT_W-1:0] cnt_w;
  logic             run_w;
  logic             tick_w;
  logic             expire_w;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_i     (cnt_w),
    .expire_i    (expire_w),
    .ctrl_o      (ctrl_w),
    .load_we_o   (load_we_w),
    .load_val_o  (load_val_w),
    .en_rise_o   (en_rise_w),
    .status_o    (expired_o)
  );

  wdog_prescaler #(
    .PSC_W(PSC_W), .PC_W(PC_W)
  ) i_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .restart_i (load_we_w || en_rise_w),
    .code_i    (ctrl_w.psc),
    .tick_o    (tick_w)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_w.en),
    .load_we_i  (load_we_w),
    .load_val_i (load_val_w),
    .tick_i     (tick_w),
    .count_o    (cnt_w),
    .run_o      (run_w),
    .expire_o   (expire_w)
  );

  wdog_rst_gen #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) i_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire_w),
    .wd_mode_i (ctrl_w.mode == MODE_WD),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned PULSE_CYCLES = 16,
  localparam int unsigned LW = $clog2(PULSE_CYCLES + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              load_we,
  input logic [CNT_W-1:0]  count,
  input logic              en,
  input logic [1:0]        mode,
  input logic              rst_req_o,
  input logic              expired_o
);
  logic [LW-1:0] hi_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_len_q <= '0;
    else if (rst_req_o) hi_len_q <= hi_len_q + 1'b1;
    else                hi_len_q <= '0;
  end

  a_r2_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we && (|bus_wdata_i[DATA_W-1:CNT_W]) |=> count == {CNT_W{1'b1}});

  a_r5_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !load_we |=> $stable(count));

  a_r11_zero_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count == '0 && !load_we |=> count == '0);

  a_r8_pulse_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> count == '0 && $past(count) == CNT_W'(1));

  a_r8_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> hi_len_q == LW'(PULSE_CYCLES));

  a_r9_wd_mode_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(mode) == 2'd3);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_we |=> expired_o);
endmodule

bind wdog_timer wdog_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)
) i_wdog_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wdata_i (bus_wdata_i),
  .load_we     (load_we_w),
  .count       (cnt_w),
  .en          (ctrl_w.en),
  .mode        (ctrl_w.mode),
  .rst_req_o   (rst_req_o),
  .expired_o   (expired_o)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  logic        expired;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .rst_req_o   (rst_req),
    .expired_o   (expired)
  );

  // vector table: prescale code, mode, load value, expected clocks to expiry
  localparam int NV = 7;
  localparam int V_PSC [NV] = '{0, 0, 1, 3, 4, 2, 15};
  localparam int V_MODE[NV] = '{3, 3, 3, 0, 1, 2, 3};
  localparam int V_LOAD[NV] = '{1, 5, 3, 2, 4, 7, 1};
  localparam int V_EXP [NV] = '{1, 5, 12, 32, 128, 56, 65536};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int en, input int mode, input int psc);
    return (32'(en) << 7) | (32'(mode) << 4) | 32'(psc);
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // clocks after the load edge until expired_o rises
  task automatic wait_expiry(input int limit, output int k);
    k = 0;
    while (!expired && k < limit) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 64) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int k;
    int plen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, rd);
    check(rd == 0, "R1 count", int'(rd), 0);
    bus_rd(4'h8, rd);
    check(rd == 0, "R1 ctrl", int'(rd), 0);
    check(!rst_req && !expired, "R1 outputs", int'({rst_req, expired}), 0);

    // R4 R8 R9 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      bus_wr(4'h8, ctrl_word(1, V_MODE[v], V_PSC[v]));
      bus_wr(4'h0, 32'(V_LOAD[v]));
      wait_expiry(V_EXP[v] + 10, k);
      check(k == V_EXP[v], "R4 expiry time", k, V_EXP[v]);
      check(rst_req == (V_MODE[v] == 3), "R8 R9 reset request", int'(rst_req),
            int'(V_MODE[v] == 3));
      if (V_MODE[v] == 3) begin
        pulse_len(plen);
        check(plen == 16, "R8 pulse width", plen, 16);
      end
      cycles(20);
      check(!rst_req, "R11 no second pulse", int'(rst_req), 0);
      check(expired, "R10 sticky", int'(expired), 1);
    end

    // R2 saturation and readback with enable clear
    bus_wr(4'h8, ctrl_word(0, 3, 0));
    bus_wr(4'h0, 32'h0001_2345);
    bus_rd(4'h0, rd);
    check(rd == 32'hFFFF, "R2 saturate", int'(rd), 32'hFFFF);
    check(!expired, "R10 cleared by load", int'(expired), 0);

    // R5 hold while disabled, countdown after enable
    bus_wr(4'h0, 32'd10);
    cycles(20);
    bus_rd(4'h0, rd);
    check(rd == 10, "R5 hold", int'(rd), 10);
    bus_wr(4'h8, ctrl_word(1, 3, 0));
    wait_expiry(30, k);
    check(k == 10, "R5 enable start", k, 10);
    cycles(20);

    // R5 prescaler restart on enable rise, divide 8
    bus_wr(4'h8, ctrl_word(0, 0, 2));
    bus_wr(4'h0, 32'd2);
    cycles(5);
    bus_wr(4'h8, ctrl_word(1, 0, 2));
    wait_expiry(40, k);
    check(k == 16, "R5 prescaler restart", k, 16);

    // R6 zero load never expires
    bus_wr(4'h8, ctrl_word(1, 3, 0));
    bus_wr(4'h0, 32'd0);
    cycles(50);
    check(!expired && !rst_req, "R6 no expiry", int'({expired, rst_req}), 0);
    bus_rd(4'h0, rd);
    check(rd == 0, "R6 count parked", int'(rd), 0);

    // R3 control readback, reserved bit 6 reads 0
    bus_wr(4'h8, 32'h0000_00F5);
    bus_rd(4'h8, rd);
    check(rd == 32'h0B5, "R3 ctrl readback", int'(rd), 32'h0B5);

    // R2 live count read
    bus_wr(4'h8, ctrl_word(1, 3, 0));
    bus_wr(4'h0, 32'd20);
    cycles(5);
    bus_rd(4'h0, rd);
    check(rd == 15, "R2 live count", int'(rd), 15);

    // R7 service mid-count
    bus_wr(4'h0, 32'd8);
    cycles(5);
    check(!expired, "R7 before service", int'(expired), 0);
    bus_wr(4'h0, 32'd8);
    wait_expiry(30, k);
    check(k == 8, "R7 restart interval", k, 8);
    pulse_len(plen);
    check(plen == 16, "R8 pulse after service", plen, 16);
    cycles(40);
    bus_rd(4'h0, rd);
    check(rd == 0 && !rst_req, "R11 parked after expiry", int'(rd), 0);

    // R9 R10 mode 0: sticky stays, no reset, cleared by load
    bus_wr(4'h8, ctrl_word(1, 0, 0));
    bus_wr(4'h0, 32'd3);
    cycles(33);
    check(expired, "R10 stays set", int'(expired), 1);
    check(!rst_req, "R9 no reset mode0", int'(rst_req), 0);
    bus_rd(4'h8, rd);
    check(rd[8] == 1'b1, "R3 status bit", int'(rd[8]), 1);
    bus_wr(4'h0, 32'd0);
    check(!expired, "R10 cleared", int'(expired), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule